// File: doc/BRIEF.md
# Burst-Programmed Word Crosspoint

This block is a 16-by-16 crosspoint switch that works on whole words. Each output register can take its word from any one of the 16 inputs. It can also be held on a fixed IDLE word, whatever its selected input is carrying.

The routing map is written through a narrow parallel port during a burst of four clock cycles:

- Each beat carries a 16-bit routing field and a 4-bit idle-override field.
- The beats are accepted only while an active-low configure enable is held low.
- A one-cycle sync pulse marks the first beat.

The beats fill a shadow copy of the map. After the fourth beat, the shadow is copied into the active map in a single step, so the outputs never run on a half-written configuration. A burst that is cut short leaves the active map as it was.

Top module: `xpt_matrix`

## Requirements
- R1: Each output not forced to IDLE presents the word of its selected input. The output is registered, so an input change shows at the output one clock later.
- R2: Beat k of a burst (k = 0..3) programs outputs 4k..4k+3. For output 4k+j, `cfg_data[4j+3:4j]` is the source input number, and `cfg_idle[j]` is its force-IDLE flag (1 = forced).
- R3: A burst begins only on a cycle where `cfg_sync` is 1 and `cfg_en_n` is 0. A sync pulse while `cfg_en_n` is 1 is ignored. Data presented with `cfg_en_n` at 0 but no preceding sync is also ignored.
- R4: The active map is replaced as a whole on the clock edge after the fourth beat is captured. Outputs keep the old map through that edge and show the new map one edge later.
- R5: If `cfg_en_n` returns to 1 before four beats have been captured, the burst is dropped and the active map does not change.
- R6: An output whose force-IDLE flag is set presents `IDLE_WORD` (default 16'h0000).
- R7: After reset, every output is forced to IDLE and every source select is 0.
- R8: A sync pulse during a burst restarts it, so the cycle carrying that pulse is taken as beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_n | input | 1 | Active-low configure enable |
| cfg_sync | input | 1 | Pulse marking the first beat of a burst |
| cfg_data | input | 16 | Four 4-bit source selects for the beat's outputs |
| cfg_idle | input | 4 | Force-IDLE flags for the beat's outputs |
| din | input | NPORT*WW | Input words; input i occupies bits [i*WW +: WW] |
| dout | output | NPORT*WW | Output words; output o occupies bits [o*WW +: WW] |

## Verification
The assertions check the following on every cycle:
- The active map changes only right after a commit.
- A commit is a single-cycle pulse preceded by four cycles of enable held low.
- Any forced output carries the IDLE word.
- Release from reset leaves all outputs forced and all selects at zero.

The bench scenarios are needed for the rest:
- The correct placement of the fields within the beats.
- The exact cycle at which the outputs move to the new map.
- That aborted bursts, stray sync pulses and unsynced data leave the outputs untouched.
- That a mid-burst sync restarts the load.
- That routed outputs follow their inputs with one cycle of latency.

// File: rtl/xpt_matrix.sv
module xpt_matrix #(
  parameter int NPORT = 16,
  parameter int WW = 16,
  parameter int GRP = 4,
  parameter logic [WW-1:0] IDLE_WORD = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en_n,
  input  logic                  cfg_sync,
  input  logic [GRP*$clog2(NPORT)-1:0] cfg_data,
  input  logic [GRP-1:0]        cfg_idle,
  input  logic [NPORT*WW-1:0]   din,
  output logic [NPORT*WW-1:0]   dout
);
  localparam int SELW  = $clog2(NPORT);
  localparam int BEATS = NPORT / GRP;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [SELW-1:0] sh_sel [NPORT];
  logic [SELW-1:0] act_sel [NPORT];
  logic [NPORT-1:0] sh_idle, act_idle;
  logic [NPORT*SELW-1:0] act_sel_flat;
  logic [CW-1:0] beat;
  logic busy, commit;
  logic [WW-1:0] din_w [NPORT];

  wire start = !cfg_en_n && cfg_sync;
  wire take  = start || (busy && !cfg_en_n);
  wire [CW-1:0] slot = start ? '0 : beat;
  wire last  = take && (slot == CW'(BEATS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      commit <= 1'b0;
      beat   <= '0;
    end else begin
      commit <= last;
      busy   <= take && !last;
      if (take) beat <= slot + CW'(1);
    end
  end

  generate
    for (genvar o = 0; o < NPORT; o++) begin : g_port
      assign din_w[o] = din[o*WW +: WW];
      assign act_sel_flat[o*SELW +: SELW] = act_sel[o];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh_sel[o]   <= '0;
          sh_idle[o]  <= 1'b1;
          act_sel[o]  <= '0;
          act_idle[o] <= 1'b1;
          dout[o*WW +: WW] <= IDLE_WORD;
        end else begin
          if (take && slot == CW'(o / GRP)) begin
            sh_sel[o]  <= cfg_data[(o % GRP)*SELW +: SELW];
            sh_idle[o] <= cfg_idle[o % GRP];
          end
          if (commit) begin
            act_sel[o]  <= sh_sel[o];
            act_idle[o] <= sh_idle[o];
          end
          dout[o*WW +: WW] <= act_idle[o] ? IDLE_WORD : din_w[act_sel[o]];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xpt_matrix_chk.sv
module xpt_matrix_chk #(
  parameter int NPORT = 16,
  parameter int WW = 16,
  parameter int SELW = 4,
  parameter logic [WW-1:0] IDLE_WORD = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_en_n,
  input logic                  commit,
  input logic [NPORT-1:0]      act_idle,
  input logic [NPORT*SELW-1:0] act_sel_flat,
  input logic [NPORT*WW-1:0]   dout
);
  // Four-beat window written out for the default geometry of four beats.
  p_commit_needs_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!cfg_en_n, 1) && $past(!cfg_en_n, 2) &&
                $past(!cfg_en_n, 3) && $past(!cfg_en_n, 4)));

  p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_map_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> ($stable(act_sel_flat) && $stable(act_idle)));

  p_reset_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((&act_idle) && act_sel_flat == '0));

  generate
    for (genvar o = 0; o < NPORT; o++) begin : g_o
      p_idle_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act_idle[o]) |-> dout[o*WW +: WW] == IDLE_WORD);
    end
  endgenerate
endmodule

bind xpt_matrix xpt_matrix_chk #(.NPORT(NPORT), .WW(WW), .SELW(SELW), .IDLE_WORD(IDLE_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .commit(commit),
  .act_idle(act_idle), .act_sel_flat(act_sel_flat), .dout(dout));

// File: tb/sim_xpt_matrix.sv
`timescale 1ns/1ps
module sim_xpt_matrix;
  localparam int N = 16, W = 16;
  logic clk = 1'b0, rst_n = 1'b0, cfg_en_n = 1'b1, cfg_sync = 1'b0;
  logic [15:0] cfg_data = '0;
  logic [3:0]  cfg_idle = '0;
  logic [N*W-1:0] din = '0;
  wire  [N*W-1:0] dout;

  always #2.5 clk = ~clk;

  xpt_matrix u0 (.clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .cfg_sync(cfg_sync),
                 .cfg_data(cfg_data), .cfg_idle(cfg_idle), .din(din), .dout(dout));

  typedef struct { int port; logic [W-1:0] exp; string req; } item_t;
  item_t q[$];
  event go;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m_sel[N]; bit m_idle[N];
  int c_sel[N]; bit c_idle[N];
  logic [W-1:0] dv[N];

  always begin
    @(go);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (dout[it.port*W +: W] !== it.exp) begin
        n_bad++;
        $display("FAIL %s out%0d actual %h expected %h", it.req, it.port,
                 dout[it.port*W +: W], it.exp);
      end
    end
  end

  task automatic set_din(int seed);
    for (int o = 0; o < N; o++) begin
      dv[o] = W'(seed*256 + o*17 + 1);
      din[o*W +: W] = dv[o];
    end
  endtask

  task automatic expect_all(string req);
    for (int o = 0; o < N; o++) begin
      item_t it;
      it.port = o;
      it.exp  = m_idle[o] ? 16'h0000 : dv[m_sel[o]];
      it.req  = req;
      q.push_back(it);
    end
    -> go;
  endtask

  task automatic beat(int k, bit s);
    cfg_en_n = 1'b0;
    cfg_sync = s;
    for (int j = 0; j < 4; j++) begin
      cfg_data[4*j +: 4] = 4'(c_sel[4*k+j]);
      cfg_idle[j] = c_idle[4*k+j];
    end
    @(negedge clk);
  endtask

  task automatic burst(int nb);
    for (int k = 0; k < nb; k++) beat(k, k == 0);
    cfg_en_n = 1'b1;
    cfg_sync = 1'b0;
  endtask

  task automatic apply_and_check(string req);
    burst(4);
    expect_all("R4");
    @(negedge clk);
    expect_all("R4");
    @(negedge clk);
    for (int o = 0; o < N; o++) begin m_sel[o] = c_sel[o]; m_idle[o] = c_idle[o]; end
    expect_all(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    set_din(1);
    for (int o = 0; o < N; o++) begin m_sel[o] = 0; m_idle[o] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_all("R7");

    // R2: reversed routing, nothing forced
    for (int o = 0; o < N; o++) begin c_sel[o] = N-1-o; c_idle[o] = 1'b0; end
    apply_and_check("R2");

    // R1: new input words appear one clock later
    set_din(2);
    @(negedge clk);
    expect_all("R1");

    // R6: broadcast of input 5 with some outputs forced
    for (int o = 0; o < N; o++) begin
      c_sel[o] = 5; c_idle[o] = (o == 2 || o == 7 || o == 13);
    end
    apply_and_check("R6");

    // R5: burst cut after two beats
    for (int o = 0; o < N; o++) begin c_sel[o] = o; c_idle[o] = 1'b0; end
    burst(2);
    repeat (4) @(negedge clk);
    expect_all("R5");

    // R3: sync with enable high, then unsynced data with enable low
    cfg_en_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cfg_sync = 1'b1; cfg_data = 16'h3210; cfg_idle = 4'h0;
      @(negedge clk);
    end
    cfg_sync = 1'b0;
    cfg_en_n = 1'b0;
    repeat (4) @(negedge clk);
    cfg_en_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_all("R3");

    // R8: sync mid-burst restarts the load
    for (int o = 0; o < N; o++) begin c_sel[o] = o; c_idle[o] = 1'b0; end
    beat(0, 1'b1);
    beat(1, 1'b0);
    for (int o = 0; o < N; o++) begin c_sel[o] = (o + 3) % N; c_idle[o] = (o == 0); end
    apply_and_check("R8");

    set_din(3);
    @(negedge clk);
    expect_all("R1");

    // R6: everything forced
    for (int o = 0; o < N; o++) begin c_sel[o] = o; c_idle[o] = 1'b1; end
    apply_and_check("R6");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule